// File: doc/BRIEF.md
# External Interrupt Pin Sampler

This block turns active-low external interrupt request pins into request flags for an interrupt polling unit. Each pin first passes through a synchroniser on the oscillator clock. After that the pin is read only once per machine cycle, on a strobe that a separate phase generator supplies at a fixed point of the 12-clock machine cycle. A per-source mode bit selects how the sample is used:

- **Level mode:** the flag simply mirrors the latest sample.
- **Falling-edge mode:** the flag is set when one sample reads high and the sample of the next machine cycle reads low.

An edge-mode flag stays set until the polling unit vectors to that source, which pulses an acknowledge input. Software can also set or clear any flag through a simple write port. Hardware events win over such a write in the same cycle.

Because the edge flag is a latch and not a fresh decision made at every poll, a falling edge that arrives while a higher-priority service routine is running is remembered. It is serviced once the blocking condition is gone. A level request is deliberately not remembered: when the pin returns high before the poll, the request disappears. Source `i` uses bit `i` of every per-source vector.

Top module: `ext_irq_sampler`

## Requirements
- R1: While reset is asserted and on the first clock after its release, `req_flag` and `flag_rdbk` are all zero.
- R2: Pin activity is seen only through the sample taken on a `sample_stb` clock. A pin that holds a level for at least three clocks before a strobe is sampled at that level. A low pulse that begins and ends between two strobes (ending at least three clocks before the next one) has no effect on any flag.
- R3: In level mode (`edge_mode[i]` = 0), on the clock edge where `sample_stb` is high, the flag becomes the inverse of the sampled pin (pin low gives 1). Between strobes the flag holds unless software writes it. `vec_ack` has no effect in this mode.
- R4: In edge mode (`edge_mode[i]` = 1), a strobe that samples low after the previous strobe sampled high sets the flag on that strobe's clock edge.
- R5: An edge-mode flag, once set, stays set across any later pin levels and strobes until a `vec_ack` pulse or a software clear for that source.
- R6: In edge mode, a `vec_ack[i]` pulse clears the flag on the next clock edge. If an edge is recognised on that same edge, the flag is set instead.
- R7: `sw_wr_en[i]` loads `sw_wr_val[i]` into the flag on the next edge, unless a hardware event for that source happens on the same edge. The hardware events are an edge set or an acknowledge in edge mode, and a strobe in level mode. A hardware event takes priority over the write.
- R8: The first strobe after reset only records the sample. A pin held low from reset through the first strobes therefore never sets an edge-mode flag.
- R9: `flag_rdbk` always shows the same value as `req_flag`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_stb | input | 1 | One-clock pulse at the fixed sample phase of each machine cycle |
| irq_pin_n | input | NUM_SRC | Raw active-low interrupt request pins |
| edge_mode | input | NUM_SRC | 1 = falling-edge triggered, 0 = level sensitive |
| vec_ack | input | NUM_SRC | One-clock pulse when the polling unit vectors to the source |
| sw_wr_en | input | NUM_SRC | Software write enable per flag |
| sw_wr_val | input | NUM_SRC | Value written to the flag by software |
| req_flag | output | NUM_SRC | Request flags presented to the polling unit |
| flag_rdbk | output | NUM_SRC | Flag readback bus for software |

## Verification
The hardest situation to reach is a collision on a single clock edge: a strobe that recognises a falling edge while `vec_ack` or a software write targets the same flag. This needs a high sample, a low pin that settles before the next strobe, and a pulse placed exactly on the strobe clock. Directed steps walk the bench's machine-cycle phase counter up to the strobe clock and raise the acknowledge or the write there. Long random runs then change pins early in each machine cycle, flip modes, and scatter acknowledges and writes over every phase, so that the collisions also recur with both sources and both modes mixed.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    // Per-source sampling state
    typedef struct packed {
        logic smp;     // level seen at the most recent strobe
        logic primed;  // at least one strobe taken since reset
        logic flag;    // request flag
    } src_state_t;

    localparam src_state_t SRC_RESET = '{smp: 1'b1, primed: 1'b0, flag: 1'b0};

endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
    parameter int  STAGES    = 2,
    parameter logic RESET_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic pin_out
);

    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = pin_in;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], pin_in};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RESET_LVL}};
        else        chain_q <= chain_d;
    end

    assign pin_out = chain_q[STAGES-1];

endmodule

// File: rtl/irq_src_sampler.sv
module irq_src_sampler
    import ext_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sample_stb,
    input  logic pin_s,       // synchronised active-low pin
    input  logic edge_mode,
    input  logic vec_ack,
    input  logic sw_wr_en,
    input  logic sw_wr_val,
    output logic flag,
    output logic smp_lvl,
    output logic primed
);

    src_state_t st_d, st_q;
    logic       edge_hit;

    always_comb begin
        st_d     = st_q;
        edge_hit = sample_stb && edge_mode && st_q.primed && st_q.smp && !pin_s;

        if (edge_mode) begin
            if (edge_hit)      st_d.flag = 1'b1;
            else if (vec_ack)  st_d.flag = 1'b0;
            else if (sw_wr_en) st_d.flag = sw_wr_val;
        end else begin
            if (sample_stb)    st_d.flag = !pin_s;
            else if (sw_wr_en) st_d.flag = sw_wr_val;
        end

        if (sample_stb) begin
            st_d.smp    = pin_s;
            st_d.primed = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SRC_RESET;
        else        st_q <= st_d;
    end

    assign flag    = st_q.flag;
    assign smp_lvl = st_q.smp;
    assign primed  = st_q.primed;

endmodule

// File: rtl/ext_irq_sampler.sv
module ext_irq_sampler #(
    parameter int NUM_SRC     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sample_stb,
    input  logic [NUM_SRC-1:0] irq_pin_n,
    input  logic [NUM_SRC-1:0] edge_mode,
    input  logic [NUM_SRC-1:0] vec_ack,
    input  logic [NUM_SRC-1:0] sw_wr_en,
    input  logic [NUM_SRC-1:0] sw_wr_val,
    output logic [NUM_SRC-1:0] req_flag,
    output logic [NUM_SRC-1:0] flag_rdbk
);

    logic [NUM_SRC-1:0] pin_synced;
    logic [NUM_SRC-1:0] smp_vec;
    logic [NUM_SRC-1:0] primed_vec;
    logic [NUM_SRC-1:0] flag_vec;

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
            irq_pin_sync #(
                .STAGES    (SYNC_STAGES),
                .RESET_LVL (1'b1)
            ) u_sync (
                .clk     (clk),
                .rst_n   (rst_n),
                .pin_in  (irq_pin_n[i]),
                .pin_out (pin_synced[i])
            );

            irq_src_sampler u_samp (
                .clk        (clk),
                .rst_n      (rst_n),
                .sample_stb (sample_stb),
                .pin_s      (pin_synced[i]),
                .edge_mode  (edge_mode[i]),
                .vec_ack    (vec_ack[i]),
                .sw_wr_en   (sw_wr_en[i]),
                .sw_wr_val  (sw_wr_val[i]),
                .flag       (flag_vec[i]),
                .smp_lvl    (smp_vec[i]),
                .primed     (primed_vec[i])
            );
        end
    endgenerate

    assign req_flag  = flag_vec;
    assign flag_rdbk = flag_vec;

endmodule

// File: rtl/ext_irq_checker.sv
module ext_irq_checker #(
    parameter int NUM_SRC = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sample_stb,
    input logic [NUM_SRC-1:0] edge_mode,
    input logic [NUM_SRC-1:0] vec_ack,
    input logic [NUM_SRC-1:0] sw_wr_en,
    input logic [NUM_SRC-1:0] sw_wr_val,
    input logic [NUM_SRC-1:0] pin_sync,
    input logic [NUM_SRC-1:0] smp_q,
    input logic [NUM_SRC-1:0] primed_q,
    input logic [NUM_SRC-1:0] req_flag
);

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
            // R3
            a_r3_level_tracks_sample: assert property (@(posedge clk) disable iff (!rst_n)
                (sample_stb && !edge_mode[i]) |=> (req_flag[i] == !$past(pin_sync[i])));
            // R2
            a_r2_level_quiet_between: assert property (@(posedge clk) disable iff (!rst_n)
                (!sample_stb && !edge_mode[i] && !sw_wr_en[i]) |=> $stable(req_flag[i]));
            // R4
            a_r4_edge_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
                (sample_stb && edge_mode[i] && primed_q[i] && smp_q[i] && !pin_sync[i])
                |=> req_flag[i]);
            // R5
            a_r5_edge_flag_latched: assert property (@(posedge clk) disable iff (!rst_n)
                (edge_mode[i] && req_flag[i] && !vec_ack[i] && !sw_wr_en[i]) |=> req_flag[i]);
            // R6
            a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
                (edge_mode[i] && vec_ack[i] && !sample_stb) |=> !req_flag[i]);
            // R7
            a_r7_hw_beats_sw: assert property (@(posedge clk) disable iff (!rst_n)
                (edge_mode[i] && vec_ack[i] && !sample_stb && sw_wr_en[i] && sw_wr_val[i])
                |=> !req_flag[i]);
            // R8
            a_r8_unprimed_no_edge: assert property (@(posedge clk) disable iff (!rst_n)
                (edge_mode[i] && !primed_q[i] && !req_flag[i] && !sw_wr_en[i]) |=> !req_flag[i]);
        end
    endgenerate

endmodule

bind ext_irq_sampler ext_irq_checker #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_stb (sample_stb),
    .edge_mode  (edge_mode),
    .vec_ack    (vec_ack),
    .sw_wr_en   (sw_wr_en),
    .sw_wr_val  (sw_wr_val),
    .pin_sync   (pin_synced),
    .smp_q      (smp_vec),
    .primed_q   (primed_vec),
    .req_flag   (req_flag)
);

// File: tb/ext_irq_sampler_bench.sv
module ext_irq_sampler_bench;

    localparam int N  = 2;
    localparam int MC = 12;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         stb;
    logic [N-1:0] pin_n, emode, ack, wen, wval;
    logic [N-1:0] req, rdbk;

    always #5 clk = ~clk;

    ext_irq_sampler #(.NUM_SRC(N), .SYNC_STAGES(2)) u_ext_irq_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_stb (stb),
        .irq_pin_n  (pin_n),
        .edge_mode  (emode),
        .vec_ack    (ack),
        .sw_wr_en   (wen),
        .sw_wr_val  (wval),
        .req_flag   (req),
        .flag_rdbk  (rdbk)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    finished = 0;
    int    phase;
    string tag;
    logic [N-1:0] m_flag, m_prev, m_primed;

    task automatic check(string t, logic [N-1:0] got, logic [N-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", t, got, exp);
        end
    endtask

    task automatic check_bit(string t, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", t, got, exp);
        end
    endtask

    // One clock: update the model from the inputs seen at the edge, compare at negedge
    task automatic step();
        @(posedge clk);
        for (int i = 0; i < N; i++) begin
            logic s, hit;
            s   = pin_n[i];
            hit = stb && emode[i] && m_primed[i] && m_prev[i] && !s;
            if (emode[i]) begin
                if (hit)         m_flag[i] = 1'b1;
                else if (ack[i]) m_flag[i] = 1'b0;
                else if (wen[i]) m_flag[i] = wval[i];
            end else begin
                if (stb)         m_flag[i] = !s;
                else if (wen[i]) m_flag[i] = wval[i];
            end
            if (stb) begin
                m_prev[i]   = s;
                m_primed[i] = 1'b1;
            end
        end
        @(negedge clk);
        check(tag, req, m_flag);
        check({tag, " readback R9"}, rdbk, m_flag);
        ack   = '0;
        wen   = '0;
        phase = (phase == MC-1) ? 0 : phase + 1;
        stb   = (phase == MC-1);
    endtask

    task automatic to_phase(int p);
        while (phase != p) step();
    endtask

    task automatic run_mc(int n);
        repeat (n * MC) step();
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1A2B_3C4D));
        tag    = "R1 reset";
        rst_n  = 1'b0;
        stb    = 1'b0;
        pin_n  = 2'b10;       // source 0 low from reset
        emode  = 2'b11;
        ack    = '0;
        wen    = '0;
        wval   = '0;
        m_flag = '0;
        m_prev = '1;
        m_primed = '0;
        phase  = 0;
        repeat (3) @(negedge clk);
        check("R1 flags in reset", req, 2'b00);
        check("R1 readback in reset", rdbk, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 flags after release", req, 2'b00);

        // R8: pin held low from reset never sets an edge flag
        tag = "R8 low from reset";
        run_mc(3);
        check_bit("R8 no false edge", req[0], 1'b0);

        // R4: high sample then low sample
        tag = "R4 edge";
        pin_n[0] = 1'b1;
        run_mc(1);
        pin_n[0] = 1'b0;
        run_mc(1);
        check_bit("R4 edge sets flag", req[0], 1'b1);

        // R5: flag latched while pin returns high
        tag = "R5 latched";
        pin_n[0] = 1'b1;
        run_mc(2);
        check_bit("R5 flag held", req[0], 1'b1);

        // R6: acknowledge clears
        tag = "R6 ack";
        to_phase(3);
        ack[0] = 1'b1;
        step();
        check_bit("R6 ack clears", req[0], 1'b0);

        // R6: edge on the acknowledge clock wins
        tag = "R6 collision";
        to_phase(0);
        pin_n[0] = 1'b0;
        to_phase(MC-1);
        ack[0] = 1'b1;
        step();
        check_bit("R6 set beats ack", req[0], 1'b1);

        // R7: software write and hardware priority
        tag = "R7 sw write";
        to_phase(4);
        wen[1] = 1'b1; wval[1] = 1'b1;
        step();
        check_bit("R7 sw sets", req[1], 1'b1);
        wen[1] = 1'b1; wval[1] = 1'b1; ack[1] = 1'b1;
        step();
        check_bit("R7 ack beats sw", req[1], 1'b0);

        // R3: level mode follows the sample, ack ignored
        tag = "R3 level";
        emode = 2'b00;
        to_phase(0);
        pin_n = 2'b01;        // source 1 low, source 0 high
        run_mc(1);
        check("R3 level follows", req, 2'b10);
        to_phase(2);
        ack = 2'b10;
        step();
        check_bit("R3 ack ignored in level mode", req[1], 1'b1);
        to_phase(0);
        pin_n[1] = 1'b1;
        to_phase(6);
        check_bit("R2 holds until strobe", req[1], 1'b1);
        run_mc(1);
        check_bit("R3 drops after strobe", req[1], 1'b0);

        // R2: short pulse between strobes is missed
        tag = "R2 short pulse";
        emode = 2'b11;
        run_mc(1);
        to_phase(2);
        pin_n[0] = 1'b0;
        to_phase(5);
        pin_n[0] = 1'b1;
        run_mc(2);
        check_bit("R2 pulse missed", req[0], 1'b0);

        // Random mixture
        tag = "R3/R4/R5/R6/R7 random";
        to_phase(0);
        for (int c = 0; c < 400; c++) begin
            if ($urandom_range(7) == 0) emode[$urandom_range(N-1)] ^= 1'b1;
            for (int p = 0; p < MC; p++) begin
                for (int i = 0; i < N; i++) begin
                    if (phase <= 8 && $urandom_range(3) == 0) pin_n[i] = ~pin_n[i];
                    if ($urandom_range(9) == 0) ack[i] = 1'b1;
                    if ($urandom_range(11) == 0) begin
                        wen[i]  = 1'b1;
                        wval[i] = 1'($urandom_range(1));
                    end
                end
                step();
            end
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule